// File: doc/BRIEF.md
# Framebuffer Test-Pattern Writer

This block sweeps every pixel position of a 320 by 240 frame and emits one 3-bit colour per pixel on a framebuffer write port. The port has a linear address, the colour data and a write strobe. The colour comes from a small fixed list of rectangles tested in priority order, and black covers everything else. After reset the block repeats the frame forever, so a memory attached to the port keeps being refilled with the same known picture. It serves as a bring-up source for a display path.

The scan machine has three states. `ST_BOOT` is the reset state, and its only transition leads to `ST_COL`. `ST_COL` advances the column. When the column count has reached the frame width, the column clears to zero and the machine takes the transition to `ST_ROW`. `ST_ROW` advances the row and always returns to `ST_COL`. When the row count has reached the frame height, the row clears to zero instead. Every machine step takes two clock cycles. The address, data and strobe therefore stay steady for a full pair of cycles, which gives a slow memory time to complete each write. Coordinates that fall outside the frame are still scanned, but their write strobe is held low.

Top module: `fbpat_writer`

## Requirements
- R1: While `rst` is high (synchronous, active high), and in the one cycle after it falls, `fb_we` is 0 and `fb_addr` is 0.
- R2: The first clock edge with `rst` low moves the machine to column stepping at column 0, row 0. Pixel (0,0) is presented from that edge on.
- R3: Whenever `fb_we` is 1, `fb_addr` equals column + row*320 and is below 76800.
- R4: Each step presents its address, data and strobe for exactly two clock cycles without change.
- R5: Within a row, columns 0 to 319 are written in increasing order, one per step. An extra step at column 320 follows with `fb_we` = 0.
- R6: After the column-320 step, one row step presents column 0 of the same row with `fb_we` = 1. Column stepping then resumes at column 0 of the next row.
- R7: The scan also visits row 240. The whole of that row, including its row step, has `fb_we` = 0. After it the scan restarts at pixel (0,0). A full frame takes 241*322 steps (155204 cycles).
- R8: Columns 0 to 14 of rows 0 to 43 are red, encoded `fb_data` = 3'b100 (bit 2 red, bit 1 green, bit 0 blue).
- R9: Where R8 does not apply, columns 20 to 299 of rows 40 to 199 are cyan, 3'b011.
- R10: Where neither R8 nor R9 applies, columns 300 to 319 of rows 200 to 239 are green (3'b010). Every other pixel is black (3'b000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_addr | output | 17 (AW) | Linear framebuffer address |
| fb_data | output | 3 | Pixel colour {R,G,B} |
| fb_we | output | 1 | Framebuffer write strobe |

## Verification
The bench probes the pixels on both sides of every rectangle edge. A design with an off-by-one limit would paint the wrong colour just inside or just outside an edge. It also checks the column-320 step, the row step and the whole of row 240. A design that wrapped too early would skip the row step. A design that failed to suppress those steps would write an address that aliases the next row, or one beyond the end of memory. Every probe is sampled in both cycles of its pair, which catches a design that strobes for only one cycle. The bench then follows the scan across the frame wrap back to pixel (0,0). It finishes with a reset in the middle of the scan to confirm that the machine restarts cleanly.

// File: rtl/fbpat_pkg.sv
package fbpat_pkg;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_COL  = 2'd1,
        ST_ROW  = 2'd2
    } scan_st_t;

    typedef logic [2:0] rgb3_t;

    localparam rgb3_t HUE_BLACK = 3'b000;
    localparam rgb3_t HUE_RED   = 3'b100;
    localparam rgb3_t HUE_GREEN = 3'b010;
    localparam rgb3_t HUE_CYAN  = 3'b011;

    // half-open box: lo <= coord < hi
    typedef struct packed {
        logic [15:0] x_lo;
        logic [15:0] x_hi;
        logic [15:0] y_lo;
        logic [15:0] y_hi;
        rgb3_t       hue;
    } box_t;

    localparam int BOX_N = 3;

    // index 0 has the highest priority
    function automatic box_t box_at(input int idx);
        box_t b;
        case (idx)
            0:       b = '{x_lo: 16'd0,   x_hi: 16'd15,  y_lo: 16'd0,   y_hi: 16'd44,  hue: HUE_RED};
            1:       b = '{x_lo: 16'd20,  x_hi: 16'd300, y_lo: 16'd40,  y_hi: 16'd200, hue: HUE_CYAN};
            default: b = '{x_lo: 16'd300, x_hi: 16'd320, y_lo: 16'd200, y_hi: 16'd240, hue: HUE_GREEN};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/fbpat_scan.sv
module fbpat_scan
    import fbpat_pkg::*;
#(
    parameter int H_PIX = 320,
    parameter int V_PIX = 240,
    parameter int XW    = $clog2(H_PIX + 1),
    parameter int YW    = $clog2(V_PIX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    output scan_st_t      st_o,
    output logic [XW-1:0] x_o,
    output logic [YW-1:0] y_o
);

    localparam logic [XW-1:0] X_END = XW'(H_PIX);
    localparam logic [YW-1:0] Y_END = YW'(V_PIX);

    scan_st_t      st_q, st_nx;
    logic [XW-1:0] x_q, x_nx;
    logic [YW-1:0] y_q, y_nx;
    logic          ph_q, ph_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_BOOT;
        else     st_q <= st_nx;
    end

    // coordinate and dwell-phase registers
    always_ff @(posedge clk) begin
        if (rst) begin
            x_q  <= '0;
            y_q  <= '0;
            ph_q <= 1'b0;
        end else begin
            x_q  <= x_nx;
            y_q  <= y_nx;
            ph_q <= ph_nx;
        end
    end

    // next state: every step dwells two cycles (phase 0 then phase 1)
    always_comb begin
        st_nx = st_q;
        x_nx  = x_q;
        y_nx  = y_q;
        ph_nx = ph_q;
        unique case (st_q)
            ST_BOOT: begin
                st_nx = ST_COL;
                x_nx  = '0;
                y_nx  = '0;
                ph_nx = 1'b0;
            end
            ST_COL: begin
                if (!ph_q) begin
                    ph_nx = 1'b1;
                end else begin
                    ph_nx = 1'b0;
                    if (x_q >= X_END) begin
                        x_nx  = '0;
                        st_nx = ST_ROW;
                    end else begin
                        x_nx = x_q + 1'b1;
                    end
                end
            end
            ST_ROW: begin
                if (!ph_q) begin
                    ph_nx = 1'b1;
                end else begin
                    ph_nx = 1'b0;
                    st_nx = ST_COL;
                    if (y_q >= Y_END) y_nx = '0;
                    else              y_nx = y_q + 1'b1;
                end
            end
            default: begin
                st_nx = ST_BOOT;
            end
        endcase
    end

    // outputs
    always_comb begin
        st_o = st_q;
        x_o  = x_q;
        y_o  = y_q;
    end

endmodule

// File: rtl/fbpat_addr.sv
module fbpat_addr
    import fbpat_pkg::*;
#(
    parameter int H_PIX = 320,
    parameter int V_PIX = 240,
    parameter int XW    = $clog2(H_PIX + 1),
    parameter int YW    = $clog2(V_PIX + 1),
    parameter int AW    = $clog2(H_PIX * V_PIX)
) (
    input  scan_st_t      st_i,
    input  logic [XW-1:0] x_i,
    input  logic [YW-1:0] y_i,
    output logic [AW-1:0] addr_o,
    output logic          we_o
);

    localparam logic [AW-1:0] ROW_PITCH = AW'(H_PIX);
    localparam logic [AW-1:0] ADDR_LIM  = AW'(H_PIX * V_PIX);

    logic [AW-1:0] lin;
    logic          in_frame;

    always_comb begin
        lin      = AW'(x_i) + AW'(y_i) * ROW_PITCH;
        in_frame = (x_i < XW'(H_PIX)) && (y_i < YW'(V_PIX));
        addr_o   = lin;
        // strobe only inside the frame, never at or past the memory end
        we_o     = (st_i != ST_BOOT) && in_frame && (lin < ADDR_LIM);
    end

endmodule

// File: rtl/fbpat_shade.sv
module fbpat_shade
    import fbpat_pkg::*;
#(
    parameter int XW = 9,
    parameter int YW = 8
) (
    input  logic [XW-1:0] x_i,
    input  logic [YW-1:0] y_i,
    output rgb3_t         hue_o
);

    logic [BOX_N-1:0] hit;
    rgb3_t            box_hue [BOX_N];

    for (genvar g = 0; g < BOX_N; g++) begin : g_box
        localparam box_t B = box_at(g);
        logic [15:0] dx, dy;
        always_comb begin
            // unsigned offset test: lo <= c < hi  <=>  (c - lo) < (hi - lo)
            dx         = 16'(x_i) - B.x_lo;
            dy         = 16'(y_i) - B.y_lo;
            hit[g]     = (dx < (B.x_hi - B.x_lo)) && (dy < (B.y_hi - B.y_lo));
            box_hue[g] = B.hue;
        end
    end

    // lowest index wins
    always_comb begin
        hue_o = HUE_BLACK;
        for (int i = BOX_N - 1; i >= 0; i--) begin
            if (hit[i]) hue_o = box_hue[i];
        end
    end

endmodule

// File: rtl/fbpat_writer.sv
module fbpat_writer
    import fbpat_pkg::*;
#(
    parameter int H_PIX = 320,
    parameter int V_PIX = 240,
    parameter int AW    = $clog2(H_PIX * V_PIX)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] fb_addr,
    output logic [2:0]    fb_data,
    output logic          fb_we
);

    localparam int XW = $clog2(H_PIX + 1);
    localparam int YW = $clog2(V_PIX + 1);

    scan_st_t      scan_st;
    logic [XW-1:0] scan_x;
    logic [YW-1:0] scan_y;

    fbpat_scan #(.H_PIX(H_PIX), .V_PIX(V_PIX), .XW(XW), .YW(YW)) u_scan (
        .clk  (clk),
        .rst  (rst),
        .st_o (scan_st),
        .x_o  (scan_x),
        .y_o  (scan_y)
    );

    fbpat_addr #(.H_PIX(H_PIX), .V_PIX(V_PIX), .XW(XW), .YW(YW), .AW(AW)) u_addr (
        .st_i   (scan_st),
        .x_i    (scan_x),
        .y_i    (scan_y),
        .addr_o (fb_addr),
        .we_o   (fb_we)
    );

    fbpat_shade #(.XW(XW), .YW(YW)) u_shade (
        .x_i   (scan_x),
        .y_i   (scan_y),
        .hue_o (fb_data)
    );

endmodule

// File: rtl/fbpat_writer_chk.sv
module fbpat_writer_chk
    import fbpat_pkg::*;
#(
    parameter int H_PIX = 320,
    parameter int V_PIX = 240,
    parameter int AW    = $clog2(H_PIX * V_PIX),
    parameter int XW    = $clog2(H_PIX + 1),
    parameter int YW    = $clog2(V_PIX + 1)
) (
    input logic          clk,
    input logic          rst,
    input scan_st_t      st,
    input logic [XW-1:0] cx,
    input logic [YW-1:0] cy,
    input logic [AW-1:0] fb_addr,
    input logic [2:0]    fb_data,
    input logic          fb_we
);

    p_boot_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!fb_we && fb_addr == '0));

    p_first_pixel_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> (st == ST_COL && cx == '0 && cy == '0));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> (int'(fb_addr) < H_PIX * V_PIX));

    p_addr_map_r3: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> (int'(fb_addr) == int'(cx) + int'(cy) * H_PIX));

    p_pair_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(fb_addr) |=> ($stable(fb_addr) && $stable(fb_we) && $stable(fb_data)));

    p_edge_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_COL && int'(cx) == H_PIX) |-> !fb_we);

    p_row_step_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_COL && int'(cx) == H_PIX && $past(st == ST_COL && int'(cx) == H_PIX))
        |=> (st == ST_ROW && cx == '0));

    p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ROW && int'(cy) == V_PIX && $past(st == ST_ROW && int'(cy) == V_PIX))
        |=> (st == ST_COL && cx == '0 && cy == '0));

    p_red_r8: assert property (@(posedge clk) disable iff (rst)
        (fb_we && int'(cx) < 15 && int'(cy) < 44) |-> (fb_data == 3'b100));

    p_cyan_r9: assert property (@(posedge clk) disable iff (rst)
        (fb_we && int'(cx) >= 20 && int'(cx) < 300 && int'(cy) >= 40 && int'(cy) < 200)
        |-> (fb_data == 3'b011));

    p_green_r10: assert property (@(posedge clk) disable iff (rst)
        (fb_we && int'(cx) >= 300 && int'(cy) >= 200) |-> (fb_data == 3'b010));

endmodule

bind fbpat_writer fbpat_writer_chk #(.H_PIX(H_PIX), .V_PIX(V_PIX), .AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .st      (scan_st),
    .cx      (scan_x),
    .cy      (scan_y),
    .fb_addr (fb_addr),
    .fb_data (fb_data),
    .fb_we   (fb_we)
);

// File: tb/fbpat_writer_test.sv
module fbpat_writer_test;

    localparam int STEPS_PER_ROW = 322;
    localparam int NV = 30;

    // {row_step, x[8:0], y[7:0], hue[2:0], we}, in scan order
    localparam logic [21:0] VEC [0:NV-1] = '{
        {1'b0, 9'd0,   8'd0,   3'b100, 1'b1},
        {1'b0, 9'd14,  8'd0,   3'b100, 1'b1},
        {1'b0, 9'd15,  8'd0,   3'b000, 1'b1},
        {1'b0, 9'd319, 8'd0,   3'b000, 1'b1},
        {1'b0, 9'd320, 8'd0,   3'b000, 1'b0},
        {1'b1, 9'd0,   8'd0,   3'b100, 1'b1},
        {1'b0, 9'd19,  8'd39,  3'b000, 1'b1},
        {1'b0, 9'd20,  8'd39,  3'b000, 1'b1},
        {1'b0, 9'd14,  8'd40,  3'b100, 1'b1},
        {1'b0, 9'd19,  8'd40,  3'b000, 1'b1},
        {1'b0, 9'd20,  8'd40,  3'b011, 1'b1},
        {1'b0, 9'd299, 8'd40,  3'b011, 1'b1},
        {1'b0, 9'd300, 8'd40,  3'b000, 1'b1},
        {1'b0, 9'd14,  8'd43,  3'b100, 1'b1},
        {1'b1, 9'd0,   8'd43,  3'b100, 1'b1},
        {1'b0, 9'd0,   8'd44,  3'b000, 1'b1},
        {1'b0, 9'd20,  8'd44,  3'b011, 1'b1},
        {1'b0, 9'd20,  8'd199, 3'b011, 1'b1},
        {1'b0, 9'd299, 8'd199, 3'b011, 1'b1},
        {1'b0, 9'd300, 8'd199, 3'b000, 1'b1},
        {1'b0, 9'd20,  8'd200, 3'b000, 1'b1},
        {1'b0, 9'd299, 8'd200, 3'b000, 1'b1},
        {1'b0, 9'd300, 8'd200, 3'b010, 1'b1},
        {1'b0, 9'd300, 8'd239, 3'b010, 1'b1},
        {1'b0, 9'd319, 8'd239, 3'b010, 1'b1},
        {1'b0, 9'd320, 8'd239, 3'b000, 1'b0},
        {1'b1, 9'd0,   8'd239, 3'b000, 1'b1},
        {1'b0, 9'd0,   8'd240, 3'b000, 1'b0},
        {1'b0, 9'd319, 8'd240, 3'b000, 1'b0},
        {1'b1, 9'd0,   8'd240, 3'b000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [16:0] fb_addr;
    logic [2:0]  fb_data;
    logic        fb_we;

    int  k = 0;
    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) k <= 0;
        else     k <= k + 1;
    end

    fbpat_writer uut (
        .clk     (clk),
        .rst     (rst),
        .fb_addr (fb_addr),
        .fb_data (fb_data),
        .fb_we   (fb_we)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic wait_k(input int t);
        while (k < t) @(negedge clk);
    endtask

    // sample step s in both cycles of its pair
    task automatic probe(input int s, input int ex, input int ey, input int hue,
                         input bit we, input string req);
        for (int c = 1; c <= 2; c++) begin
            string tag;
            wait_k(2 * s + c);
            tag = (c == 2) ? "R4" : req;
            check(fb_we == we, tag, "write strobe", int'(fb_we), int'(we));
            if (we) begin
                check(int'(fb_addr) == ex + ey * 320, "R3", "address",
                      int'(fb_addr), ex + ey * 320);
                check(int'(fb_data) == hue, tag, "colour", int'(fb_data), hue);
            end
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet during reset
        check(fb_we == 1'b0, "R1", "strobe in reset", int'(fb_we), 0);
        check(fb_addr == '0, "R1", "address in reset", int'(fb_addr), 0);
        rst = 1'b0;

        // table walk; entry 0 is the first pixel after release (R2)
        for (int i = 0; i < NV; i++) begin
            logic [21:0] v;
            int vx, vy, vh, s;
            bit vr, vw;
            string req;
            v  = VEC[i];
            vr = v[21];
            vx = int'(v[20:12]);
            vy = int'(v[11:4]);
            vh = int'(v[3:1]);
            vw = v[0];
            s  = vr ? (vy * STEPS_PER_ROW + 321) : (vy * STEPS_PER_ROW + vx);
            if (i == 0)          req = "R2";
            else if (vr && vw)   req = "R6";
            else if (vy == 240)  req = "R7";
            else if (!vw)        req = "R5";
            else if (vh == 4)    req = "R8";
            else if (vh == 3)    req = "R9";
            else                 req = "R10";
            probe(s, vx, vy, vh, vw, req);
        end

        // R7: frame wraps back to (0,0) then (1,0)
        probe(241 * STEPS_PER_ROW, 0, 0, 4, 1'b1, "R7");
        probe(241 * STEPS_PER_ROW + 1, 1, 0, 4, 1'b1, "R7");

        // reset in the middle of the scan (R1), then clean restart (R2)
        probe(241 * STEPS_PER_ROW + 30, 30, 0, 0, 1'b1, "R10");
        rst = 1'b1;
        @(negedge clk);
        check(fb_we == 1'b0, "R1", "strobe after mid-scan reset", int'(fb_we), 0);
        check(fb_addr == '0, "R1", "address after mid-scan reset", int'(fb_addr), 0);
        @(negedge clk);
        rst = 1'b0;
        probe(0, 0, 0, 4, 1'b1, "R2");
        probe(1, 1, 0, 4, 1'b1, "R5");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #1_800_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R7 watchdog: scan did not complete, actual step %0d expected %0d",
                     k / 2, 241 * STEPS_PER_ROW);
            summary();
            $finish;
        end
    end

endmodule